// File: doc/BRIEF.md
# Banked Expansion Memory Select Decoder

This block sits on the host side of an expansion card that carries a battery-backed SRAM and an EPROM. The card's memory takes over the top quarter of a 16-bit Z80 address space (C000h to FFFFh). It appears there only when the bank number that software last wrote matches the identifiers set by jumpers on the card. The block watches I/O writes and latches a bank number from those whose upper address byte is DFh. It compares the latched value against three jumper values. The EPROM uses the full byte. The SRAM read and SRAM write identifiers use only the low nibble.

From that comparison, the host memory strobes and the host's upper-ROM enable, it drives active-low chip selects for both memories, a write strobe for the SRAM and a read-data drive enable. It also drives an active-high ROM-disable request back to the host. SRAM writes never block the host's own RAM, so a write hit lands in both places.

Top module: `bank_sel_top`

## Requirements
- R1: After reset the latched bank is 00h. With no memory request inside the window, every active-low select (`eprom_cs_n`, `sram_cs_n`, `sram_we_n`, `exp_oe_n`) is high and `host_romdis` is low.
- R2: On a clock edge with `iorq_n`=0, `wr_n`=0 and `addr[15:8]`=DFh, the bank register loads `data_in`, whatever `addr[7:0]` is. I/O writes to any other upper byte leave it unchanged. Memory writes also leave it unchanged.
- R3: No select is asserted unless `mreq_n`=0 and `addr[15:14]`=2'b11. So 0000h–BFFFh never select, and C000h–FFFFh can.
- R4: An EPROM read (`eprom_cs_n`=0) needs all 8 bank bits to equal `eprom_id`, together with a qualified window read.
- R5: An SRAM read (`sram_cs_n`=0, `sram_we_n`=1) needs bank bits [3:0] to equal `sram_rd_id`. Bank bits [7:4] are ignored.
- R6: An SRAM write (`sram_cs_n`=0, `sram_we_n`=0) needs `wr_n`=0 in the window and bank bits [3:0] equal to `sram_wr_id`. It occurs whatever the level of `upper_rom_en`.
- R7: Read selects, `exp_oe_n`=0 and `host_romdis`=1 appear only while `upper_rom_en`=1.
- R8: When the EPROM and SRAM read compares both match, only the EPROM is selected. `eprom_cs_n` and an SRAM read select are never both low.
- R9: `host_romdis` is 1 exactly during a qualified expansion read, and `exp_oe_n` is low at the same time. During an SRAM write hit, `host_romdis` stays 0 and `exp_oe_n` stays 1, so host RAM still takes the write.
- R10: Selects follow `addr`, `mreq_n`, `rd_n`, `wr_n` and `upper_rom_en` within the same cycle, with no register delay. They use the bank value registered at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 16 | Host address bus |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| data_in | input | 8 | Host data bus (bank number on I/O write) |
| upper_rom_en | input | 1 | Host upper-ROM enable, active high |
| eprom_id | input | 8 | EPROM bank jumpers |
| sram_rd_id | input | 4 | SRAM read bank jumpers |
| sram_wr_id | input | 4 | SRAM write bank jumpers |
| eprom_cs_n | output | 1 | EPROM chip select |
| sram_cs_n | output | 1 | SRAM chip select |
| sram_we_n | output | 1 | SRAM write enable |
| exp_oe_n | output | 1 | Expansion read-data drive enable |
| host_romdis | output | 1 | Request to disable host ROM |

## Verification
The bench loads bank values that match only the EPROM, only the SRAM read nibble, both of these, or only the SRAM write nibble. It then issues reads and writes with upper-ROM enable high and low. This separates full-byte matching from nibble matching and shows the EPROM priority. It also shows that reads depend on upper-ROM enable while writes do not. Bank values that differ only in the upper nibble show that the SRAM compare ignores those bits. I/O writes to a neighbouring port and memory writes to DFxxh show that only the intended port loads the bank. Accesses at BFFFh and C000h mark the edge of the window.

// File: rtl/bank_sel_pkg.sv
package bank_sel_pkg;

    // Outputs of the select generator, all combinational.
    typedef struct packed {
        logic eprom_cs_n;
        logic sram_cs_n;
        logic sram_we_n;
        logic exp_oe_n;
        logic host_romdis;
    } sel_out_t;

    localparam sel_out_t SEL_IDLE = '{eprom_cs_n: 1'b1, sram_cs_n: 1'b1,
                                      sram_we_n: 1'b1, exp_oe_n: 1'b1,
                                      host_romdis: 1'b0};

endpackage

// File: rtl/bank_latch.sv
module bank_latch #(
    parameter int          ADDR_W  = 16,
    parameter int          BANK_W  = 8,
    parameter int          HI_W    = ADDR_W / 2,
    parameter logic [HI_W-1:0] PORT_HI = 8'hDF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              iorq_n,
    input  logic              wr_n,
    input  logic [BANK_W-1:0] data_in,
    output logic [BANK_W-1:0] bank_q
);

    typedef struct packed {
        logic [BANK_W-1:0] bank;
    } latch_st_t;

    latch_st_t st_d, st_q;
    logic      port_hit;

    // Only the upper address byte takes part in the port decode.
    assign port_hit = !iorq_n && !wr_n && (addr[ADDR_W-1:ADDR_W-HI_W] == PORT_HI);

    always_comb begin
        st_d = st_q;
        if (port_hit) begin
            st_d.bank = data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_q = st_q.bank;

    // R2: a port write is visible on the next cycle.
    p_bank_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        port_hit |=> (bank_q == $past(data_in)));

    // R2: anything else leaves the bank alone.
    p_bank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !port_hit |=> $stable(bank_q));

endmodule

// File: rtl/bank_match.sv
module bank_match #(
    parameter int BANK_W = 8,
    parameter int CMP_W  = 4
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [CMP_W-1:0]  id,
    output logic              hit
);

    logic [CMP_W-1:0] bit_eq;

    // One equality cell per compared bit; bits above CMP_W are don't-care.
    for (genvar i = 0; i < CMP_W; i++) begin : g_bit
        assign bit_eq[i] = ~(bank[i] ^ id[i]);
    end

    assign hit = &bit_eq;

endmodule

// File: rtl/sel_gen.sv
module sel_gen
    import bank_sel_pkg::*;
#(
    parameter int               ADDR_W = 16,
    parameter int               WIN_W  = 2,
    parameter logic [WIN_W-1:0] WIN_TAG = 2'b11
) (
    input  logic              [WIN_W-1:0] addr_top,
    input  logic                          mreq_n,
    input  logic                          rd_n,
    input  logic                          wr_n,
    input  logic                          upper_rom_en,
    input  logic                          eprom_hit,
    input  logic                          sram_rd_hit,
    input  logic                          sram_wr_hit,
    output sel_out_t                      sel
);

    logic in_win;
    logic eprom_rd;
    logic sram_rd;
    logic sram_wr;

    always_comb begin
        in_win   = !mreq_n && (addr_top == WIN_TAG);
        eprom_rd = in_win && !rd_n && upper_rom_en && eprom_hit;
        // EPROM wins when both read compares match.
        sram_rd  = in_win && !rd_n && upper_rom_en && sram_rd_hit && !eprom_hit;
        // Writes ignore the ROM enable and never touch the host side.
        sram_wr  = in_win && !wr_n && sram_wr_hit;

        sel             = SEL_IDLE;
        sel.eprom_cs_n  = !eprom_rd;
        sel.sram_cs_n   = !(sram_rd || sram_wr);
        sel.sram_we_n   = !sram_wr;
        sel.exp_oe_n    = !(eprom_rd || sram_rd);
        sel.host_romdis = eprom_rd || sram_rd;
    end

endmodule

// File: rtl/bank_sel_top.sv
module bank_sel_top
    import bank_sel_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int BANK_W  = 8,
    parameter int SRAM_W  = 4,
    parameter int WIN_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mreq_n,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [BANK_W-1:0] data_in,
    input  logic              upper_rom_en,
    input  logic [BANK_W-1:0] eprom_id,
    input  logic [SRAM_W-1:0] sram_rd_id,
    input  logic [SRAM_W-1:0] sram_wr_id,
    output logic              eprom_cs_n,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              exp_oe_n,
    output logic              host_romdis
);

    logic [BANK_W-1:0] bank_q;
    logic              eprom_hit;
    logic              sram_rd_hit;
    logic              sram_wr_hit;
    sel_out_t          sel;

    bank_latch #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .iorq_n  (iorq_n),
        .wr_n    (wr_n),
        .data_in (data_in),
        .bank_q  (bank_q)
    );

    bank_match #(.BANK_W(BANK_W), .CMP_W(BANK_W)) u_eprom_cmp (
        .bank (bank_q), .id (eprom_id), .hit (eprom_hit)
    );

    bank_match #(.BANK_W(BANK_W), .CMP_W(SRAM_W)) u_sram_rd_cmp (
        .bank (bank_q), .id (sram_rd_id), .hit (sram_rd_hit)
    );

    bank_match #(.BANK_W(BANK_W), .CMP_W(SRAM_W)) u_sram_wr_cmp (
        .bank (bank_q), .id (sram_wr_id), .hit (sram_wr_hit)
    );

    sel_gen #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_sel (
        .addr_top     (addr[ADDR_W-1:ADDR_W-WIN_W]),
        .mreq_n       (mreq_n),
        .rd_n         (rd_n),
        .wr_n         (wr_n),
        .upper_rom_en (upper_rom_en),
        .eprom_hit    (eprom_hit),
        .sram_rd_hit  (sram_rd_hit),
        .sram_wr_hit  (sram_wr_hit),
        .sel          (sel)
    );

    assign eprom_cs_n  = sel.eprom_cs_n;
    assign sram_cs_n   = sel.sram_cs_n;
    assign sram_we_n   = sel.sram_we_n;
    assign exp_oe_n    = sel.exp_oe_n;
    assign host_romdis = sel.host_romdis;

    // R3: outside the window or without a memory request, nothing is selected.
    p_no_sel_outside_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_n || (addr[ADDR_W-1:ADDR_W-WIN_W] != '1)) |->
        (eprom_cs_n && sram_cs_n && exp_oe_n && !host_romdis));

    // R7: read-side outputs need the host ROM enable.
    p_reads_need_urom_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !upper_rom_en |-> (eprom_cs_n && exp_oe_n && !host_romdis));

    // R8: never two read drivers at once.
    p_single_driver_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!eprom_cs_n, (!sram_cs_n && sram_we_n)}));

    // R9: a write strobe never disables the host ROM or drives read data.
    p_write_no_romdis_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!host_romdis && exp_oe_n));

    // R4: the EPROM is selected only on a full-byte bank match.
    p_eprom_full_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !eprom_cs_n |-> (bank_q == eprom_id));

endmodule

// File: tb/test_bank_sel_top.sv
module test_bank_sel_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0]  data_in = 8'h00;
    logic        upper_rom_en = 1'b0;
    logic [7:0]  eprom_id = 8'hA5;
    logic [3:0]  sram_rd_id = 4'h5;
    logic [3:0]  sram_wr_id = 4'h3;
    logic        eprom_cs_n, sram_cs_n, sram_we_n, exp_oe_n, host_romdis;

    always #2 clk = ~clk;   // 250 MHz

    bank_sel_top i_bank_sel_top (
        .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .iorq_n(iorq_n),
        .rd_n(rd_n), .wr_n(wr_n), .data_in(data_in), .upper_rom_en(upper_rom_en),
        .eprom_id(eprom_id), .sram_rd_id(sram_rd_id), .sram_wr_id(sram_wr_id),
        .eprom_cs_n(eprom_cs_n), .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n),
        .exp_oe_n(exp_oe_n), .host_romdis(host_romdis)
    );

    typedef struct {
        logic [4:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int    total = 0;
    int    bad   = 0;
    logic [7:0] m_bank = 8'h00;   // bench's own view of the bank register
    bit    done = 1'b0;

    // Expected outputs {eprom_cs_n, sram_cs_n, sram_we_n, exp_oe_n, host_romdis}
    function automatic logic [4:0] model(logic [15:0] a, logic mq, logic rd, logic wr,
                                         logic ur, logic [7:0] bk);
        logic win, em, er, sr, sw;
        win = !mq && (a[15:14] == 2'b11);
        em  = (bk == eprom_id);
        er  = win && !rd && ur && em;
        sr  = win && !rd && ur && (bk[3:0] == sram_rd_id) && !em;
        sw  = win && !wr && (bk[3:0] == sram_wr_id);
        return {!er, !(sr || sw), !sw, !(er || sr), (er || sr)};
    endfunction

    // Driver: apply one bus cycle at the falling edge and queue the expectation.
    task automatic step(input logic [15:0] a, input logic mq, input logic io,
                        input logic rd, input logic wr, input logic [7:0] d,
                        input logic ur, input string tag);
        item_t it;
        @(negedge clk);
        addr = a; mreq_n = mq; iorq_n = io; rd_n = rd; wr_n = wr;
        data_in = d; upper_rom_en = ur;
        it.exp = model(a, mq, rd, wr, ur, m_bank);
        it.tag = tag;
        q.push_back(it);
        if (!io && !wr && a[15:8] == 8'hDF) m_bank = d;   // takes effect at next edge
    endtask

    task automatic mem_rd(input logic [15:0] a, input logic ur, input string tag);
        step(a, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, ur, tag);
    endtask

    task automatic mem_wr(input logic [15:0] a, input logic [7:0] d, input logic ur,
                          input string tag);
        step(a, 1'b0, 1'b1, 1'b1, 1'b0, d, ur, tag);
    endtask

    task automatic io_wr(input logic [15:0] a, input logic [7:0] d, input string tag);
        step(a, 1'b1, 1'b0, 1'b1, 1'b0, d, 1'b1, tag);
    endtask

    // Monitor: compare one queued item, 1 ns after its inputs settled.
    initial begin
        forever begin
            wait (q.size() > 0);
            #1;
            begin
                item_t it;
                logic [4:0] act;
                it  = q.pop_front();
                act = {eprom_cs_n, sram_cs_n, sram_we_n, exp_oe_n, host_romdis};
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s: actual=%b expected=%b", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset state, idle and in-window with bank 00h
        step(16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1, "R1 idle after reset");
        @(negedge clk); rst_n = 1'b1;
        step(16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1, "R1 idle");
        mem_rd(16'hC000, 1'b1, "R1 bank 00h matches nothing");

        // R2 load with arbitrary low byte; R8 both compares match
        io_wr(16'hDF37, 8'hA5, "R2 load A5");
        mem_rd(16'hC000, 1'b1, "R8 EPROM priority, R4 full match");
        mem_rd(16'hFFFF, 1'b1, "R10 same-cycle select at FFFFh");
        mem_rd(16'hFFFF, 1'b0, "R7 no read without upper ROM enable");
        mem_rd(16'hBFFF, 1'b1, "R3 BFFFh outside window");
        mem_rd(16'h8000, 1'b1, "R3 8000h outside window");
        step(16'hC000, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, "R3 no mreq");
        mem_wr(16'hE000, 8'h11, 1'b1, "R6 write id 3 vs bank A5 no hit");

        // R5 nibble match, R4 byte mismatch
        io_wr(16'hDF00, 8'h75, "R2 load 75");
        mem_rd(16'hC123, 1'b1, "R5 SRAM read low nibble");
        mem_rd(16'hC123, 1'b0, "R7 SRAM read blocked");
        io_wr(16'hDFFF, 8'hF5, "R2 load F5");
        mem_rd(16'hD000, 1'b1, "R5 upper nibble ignored");

        // R2 ignored writes
        io_wr(16'hDE00, 8'hA5, "R2 neighbour port");
        mem_rd(16'hD000, 1'b1, "R2 bank still F5 after DEh write");
        mem_wr(16'hDF00, 8'hA5, 1'b1, "R2 memory write to DFxxh");
        mem_rd(16'hD000, 1'b1, "R2 bank still F5 after memory write");
        io_wr(16'hE000, 8'hA5, "R2 port E0h");
        mem_rd(16'hD000, 1'b1, "R2 bank still F5 after E0h write");

        // R6 / R9 writes
        io_wr(16'hDF01, 8'h23, "R2 load 23");
        mem_wr(16'hFFFF, 8'h5A, 1'b1, "R6 R9 SRAM write urom on");
        mem_wr(16'hC000, 8'h5A, 1'b0, "R6 R9 SRAM write urom off");
        mem_wr(16'h7FFF, 8'h5A, 1'b1, "R3 write outside window");
        mem_rd(16'hC000, 1'b1, "R5 read id 5 vs 3 no hit");
        io_wr(16'hDF02, 8'hE3, "R2 load E3");
        mem_wr(16'hC000, 8'h00, 1'b1, "R6 upper nibble ignored");

        // R4 byte mismatch in upper nibble only
        eprom_id = 8'h53;
        sram_rd_id = 4'h3;
        mem_rd(16'hC000, 1'b1, "R4 upper nibble differs, R5 SRAM wins");
        io_wr(16'hDF00, 8'h53, "R2 load 53");
        mem_rd(16'hC000, 1'b1, "R8 R9 EPROM read romdis");
        step(16'hC000, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1, "R1 idle end");

        wait (q.size() == 0);
        #2;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule